// File: doc/BRIEF.md
# Bridge fault protection sequencer

This block supervises the power stage of a driver with two full bridges. Each bridge has two high-side switches whose current arrives as a quantised code. When the summed high-side current of a bridge reaches a programmable limit, the block waits a short intervention time and then switches that bridge off. It keeps the bridge off for a programmable disable time and then lets it run again without outside help. A short circuit that persists therefore produces an endless trip, disable and retry pattern, which bounds the r.m.s. current. The two bridges are handled independently.

Two global guards sit above the per-bridge sequencers. An over-temperature guard and a supply-undervoltage guard each compare an unsigned code against a trip level and a separate release level, so each has hysteresis. While either guard is active, both bridges are off. Each bridge has an active-low fault flag that behaves like an open-drain line. The flag is pulled low while the bridge is in its overcurrent disable time or while the thermal guard is active. An undervoltage condition does not pull the flag low. All timing is counted in clock cycles; there is no analog timing network.

Top module: `bridge_guard`

## Requirements
- R1: After reset the supply guard is active, so `bridge_off` is 2'b11 and `fault_n` is 2'b11 until the supply code is raised above the release level.
- R2: Bridge b (b = 0 or 1) trips when `hs_cur[2b] + hs_cur[2b+1]` ≥ `oc_limit`. The sum is taken without overflow. The inputs are sampled at a clock edge while that bridge is running.
- R3: `bridge_off[b]` rises exactly `dly_cyc`+1 edges after the edge that samples the trip. The bridge stays on until then.
- R4: The disable lasts `off_cyc`+1 cycles, after which the bridge runs again. If the overcurrent persists, the pattern repeats with a period of `dly_cyc`+`off_cyc`+3 cycles.
- R5: A trip on one bridge never changes `bridge_off` or `fault_n` of the other bridge.
- R6: An overcurrent seen during the intervention delay or the disable time has no effect. It neither extends the disable nor starts a new trip once the bridge has re-enabled.
- R7: A temperature code above `ot_trip` sets the thermal guard one edge later, which switches both bridges off. The guard clears only after the code falls below `ot_rel`.
- R8: A supply code below `uv_trip` sets the supply guard one edge later, which switches both bridges off. The guard clears only after the code rises above `uv_rel`.
- R9: `fault_n[b]` is low exactly when bridge b is in its overcurrent disable time or the thermal guard is set. It is not pulled low by the supply guard alone.
- R10: While either guard is set, no overcurrent trip can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_cur | input | 4×IW | High-side current codes; entries 0,1 belong to bridge 0 and entries 2,3 to bridge 1 |
| oc_limit | input | IW+1 | Overcurrent trip level for the summed current |
| dly_cyc | input | CW | Intervention delay in cycles |
| off_cyc | input | CW | Disable time in cycles |
| temp_code | input | TW | Die temperature code |
| ot_trip | input | TW | Thermal trip level (strictly above) |
| ot_rel | input | TW | Thermal release level (strictly below) |
| vs_code | input | VW | Supply voltage code |
| uv_trip | input | VW | Undervoltage trip level (strictly below) |
| uv_rel | input | VW | Undervoltage release level (strictly above) |
| bridge_off | output | 2 | 1 = all switches of that bridge off |
| fault_n | output | 2 | Active-low fault flag per bridge |

## Verification
The guard outputs follow the edge that samples a temperature or supply code. The bench therefore drives each code on a falling edge and compares the outputs on the next falling edge against a hysteresis model kept in the bench. For an overcurrent, counting from the sampling edge as edge 1, `bridge_off` is expected high from edge `dly_cyc`+2 through edge `dly_cyc`+`off_cyc`+2. The bench checks every cycle of two full periods against that formula for a grid of delay and disable values. The trip comparison is checked for every pair of small current codes on both bridges, two edges after they are applied.

// File: rtl/bridge_guard.sv
module bridge_guard #(
  parameter int IW = 8,
  parameter int CW = 16,
  parameter int TW = 8,
  parameter int VW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3:0][IW-1:0]   hs_cur,
  input  logic [IW:0]          oc_limit,
  input  logic [CW-1:0]        dly_cyc,
  input  logic [CW-1:0]        off_cyc,
  input  logic [TW-1:0]        temp_code,
  input  logic [TW-1:0]        ot_trip,
  input  logic [TW-1:0]        ot_rel,
  input  logic [VW-1:0]        vs_code,
  input  logic [VW-1:0]        uv_trip,
  input  logic [VW-1:0]        uv_rel,
  output logic [1:0]           bridge_off,
  output logic [1:0]           fault_n
);
  localparam int SW = IW + 1;

  typedef enum logic [1:0] {RUN, ARM, HOLD} st_t;

  logic ot_q, uv_q;
  wire  glob_off = ot_q | uv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ot_q <= 1'b0;
      uv_q <= 1'b1;
    end else begin
      if (temp_code > ot_trip)     ot_q <= 1'b1;
      else if (temp_code < ot_rel) ot_q <= 1'b0;
      if (vs_code < uv_trip)       uv_q <= 1'b1;
      else if (vs_code > uv_rel)   uv_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_br
    logic [SW-1:0] sum;
    st_t           st;
    logic [CW-1:0] cnt;

    assign sum = {1'b0, hs_cur[2*b]} + {1'b0, hs_cur[2*b+1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= RUN;
        cnt <= '0;
      end else begin
        case (st)
          RUN:
            if (!glob_off && sum >= oc_limit) begin
              st  <= ARM;
              cnt <= dly_cyc;
            end
          ARM:
            if (cnt == '0) begin
              st  <= HOLD;
              cnt <= off_cyc;
            end else cnt <= cnt - 1'b1;
          HOLD:
            if (cnt == '0) st <= RUN;
            else cnt <= cnt - 1'b1;
          default: st <= RUN;
        endcase
      end
    end

    assign bridge_off[b] = glob_off | (st == HOLD);
    assign fault_n[b]    = ~(ot_q | (st == HOLD));
  end
endmodule

// File: rtl/bridge_guard_chk.sv
module bridge_guard_chk #(
  parameter int TW = 8,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] temp_code,
  input logic [TW-1:0] ot_trip,
  input logic [VW-1:0] vs_code,
  input logic [VW-1:0] uv_trip,
  input logic [1:0]    bridge_off,
  input logic [1:0]    fault_n
);
  a_r7_hot_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > ot_trip) |=> (bridge_off == 2'b11));

  a_r7_hot_flags_both: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code > ot_trip) |=> (fault_n == 2'b00));

  a_r8_low_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_code < uv_trip) |=> (bridge_off == 2'b11));

  a_r9_flag_implies_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((~fault_n & ~bridge_off) == 2'b00));
endmodule

bind bridge_guard bridge_guard_chk #(.TW(TW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .ot_trip(ot_trip),
  .vs_code(vs_code), .uv_trip(uv_trip), .bridge_off(bridge_off), .fault_n(fault_n)
);

// File: tb/sim_bridge_guard.sv
module sim_bridge_guard;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4, CW = 8, TW = 8, VW = 8;

  logic clk = 0, rst_n = 0;
  logic [3:0][IW-1:0] hs_cur = '0;
  logic [IW:0]   oc_limit = 5'd20;
  logic [CW-1:0] dly_cyc = 0, off_cyc = 1;
  logic [TW-1:0] temp_code = 20, ot_trip = 100, ot_rel = 90;
  logic [VW-1:0] vs_code = 0, uv_trip = 50, uv_rel = 60;
  logic [1:0] bridge_off, fault_n;

  int checks = 0, fails = 0;
  bit done = 0;

  bridge_guard #(.IW(IW), .CW(CW), .TW(TW), .VW(VW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ot_e, uv_e;
    idle(2);
    rst_n = 1;
    idle(2);
    chk("R1 off at reset", bridge_off, 3);
    chk("R1 flag at reset", fault_n, 3);
    vs_code = 100;
    idle(1);
    chk("R8 release after reset", bridge_off, 0);

    // R2 / R5: trip comparison swept on both bridges
    dly_cyc = 0; off_cyc = 1;
    for (int br = 0; br < 2; br++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          hs_cur = '0;
          hs_cur[2*br] = a[IW-1:0];
          hs_cur[2*br+1] = b[IW-1:0];
          idle(1);
          hs_cur = '0;
          idle(1);
          chk("R2 trip compare", bridge_off[br], (a + b >= 20) ? 1 : 0);
          chk("R9 trip flag", fault_n[br], (a + b >= 20) ? 0 : 1);
          chk("R5 other bridge", bridge_off[1-br], 0);
          idle(4);
          chk("R4 re-enable", bridge_off, 0);
        end

    // R3 / R4 / R6: timing grid
    for (int d = 0; d < 4; d++)
      for (int t = 0; t < 5; t++) begin
        int p;
        p = d + t + 3;
        dly_cyc = d[CW-1:0]; off_cyc = t[CW-1:0];
        idle(1);
        hs_cur[0] = 15; hs_cur[1] = 5;
        for (int j = 1; j <= 2*p; j++) begin
          int ph, e;
          idle(1);
          ph = (j - 1) % p;
          e = (ph >= d + 1 && ph <= d + t + 1) ? 1 : 0;
          chk("R3 R4 persistent pattern", bridge_off[0], e);
          chk("R9 flag pattern", fault_n[0], 1 - e);
          chk("R5 bridge 1 untouched", {bridge_off[1], fault_n[1]}, 1);
        end
        hs_cur = '0;
        idle(p + 2);
        chk("R4 idle after release", bridge_off, 0);
        hs_cur[2] = 15; hs_cur[3] = 15;
        for (int j = 1; j <= d + t + 2; j++) idle(1);
        chk("R6 still disabled", bridge_off[1], 1);
        hs_cur = '0;
        for (int j = 0; j < d + t + 6; j++) begin
          idle(1);
          chk("R6 late flags ignored", bridge_off[1], 0);
        end
      end

    // R7: thermal hysteresis sweep
    ot_e = 0;
    for (int i = 0; i <= 60; i++) begin
      int tv;
      tv = (i <= 30) ? 80 + i : 140 - i;
      temp_code = tv[TW-1:0];
      if (tv > 100) ot_e = 1; else if (tv < 90) ot_e = 0;
      idle(1);
      chk("R7 thermal off", bridge_off, ot_e ? 3 : 0);
      chk("R9 thermal flag", fault_n, ot_e ? 0 : 3);
    end
    temp_code = 20;
    idle(1);

    // R8: supply hysteresis sweep
    uv_e = 0;
    for (int i = 0; i <= 60; i++) begin
      int v;
      v = (i <= 30) ? 40 + i : 100 - i;
      vs_code = v[VW-1:0];
      if (v < 50) uv_e = 1; else if (v > 60) uv_e = 0;
      idle(1);
      chk("R8 supply off", bridge_off, uv_e ? 3 : 0);
      chk("R9 no flag on supply", fault_n, 3);
    end

    // R10: overcurrent while a guard is set
    dly_cyc = 2; off_cyc = 3;
    hs_cur[0] = 15; hs_cur[1] = 5;
    idle(3);
    hs_cur = '0;
    vs_code = 100;
    for (int j = 0; j < 10; j++) begin
      idle(1);
      chk("R10 no trip under supply guard", bridge_off, 0);
    end
    temp_code = 120;
    idle(1);
    hs_cur[2] = 15; hs_cur[3] = 15;
    idle(3);
    hs_cur = '0;
    temp_code = 20;
    for (int j = 0; j < 10; j++) begin
      idle(1);
      chk("R10 no trip under thermal guard", bridge_off, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule